// File: doc/BRIEF.md
# Shared-Bus Memory Bank Selector

This block sits between a host bus and two memories that share one set of address, data and strobe lines: a flash array and an SRAM. Three bank enables pick the target. The flash enable is active-low. The SRAM needs two enables together: one active-low and one active-high. From these enables and the shared read and write strobes, the block produces per-bank select, output-enable and write-strobe signals. For SRAM accesses it also produces a byte-lane enable for each half of the word.

The block reports standby when no bank is chosen. It raises a conflict flag when the forbidden all-asserted combination appears. While that flag is up, nothing drives the bus and nothing is written. The shared 16-bit read path is modelled as a data word plus one drive enable per byte lane. A lane whose enable is low stands for a released (high-impedance) bus lane. The SRAM behind the selector is a small, byte-writable behavioural array. It is visible only inside the lowest 512K-word window of the address space.

Top module: `shared_bus_bank_sel`

## Requirements
- R1: The flash is selected (`flash_sel`=1) exactly when `bank_f_n` is 0 and the conflict combination is absent. `flash_oe` is `flash_sel` with `oe_n`=0.
- R2: The SRAM is selected (`sram_sel`=1) only when `bank_s_n`=0, `bank_s_hi`=1, no conflict is present, and address bits above bit 18 are all zero (the lowest 512K words).
- R3: `standby` is 1 in two cases: both `bank_f_n` and `bank_s_n` are 1, or `bank_f_n` is 1 and `bank_s_hi` is 0.
- R4: `conflict` is 1 exactly when `bank_f_n`=0, `bank_s_n`=0 and `bank_s_hi`=1. While it is 1, `dq_oe` is 0, `flash_we` is 0, and the SRAM contents do not change.
- R5: A flash read (`flash_sel`=1, `oe_n`=0, `we_n`=1) drives both lanes (`dq_oe`=2'b11) with `dq_out` equal to `flash_rdata`.
- R6: An SRAM read (`sram_sel`=1, `oe_n`=0, `we_n`=1) drives only the lanes whose enable is low. `dq_oe[1]` follows `ub_n`=0 for bits 15:8, and `dq_oe[0]` follows `lb_n`=0 for bits 7:0. An undriven lane reads as zero in `dq_out`.
- R7: On a rising clock edge with `sram_sel`=1 and `we_n`=0, the SRAM word at address bits 5:0 takes `wdata` in each lane whose enable is low. Other lanes keep their contents. `sram_lane_en` is {~`ub_n`, ~`lb_n`} while `sram_sel`=1, and 0 otherwise.
- R8: `flash_we` is 1 exactly when `flash_sel`=1, `we_n`=0 and `oe_n`=1. A low `oe_n` inhibits the flash write strobe.
- R9: When no read condition holds (neither R5 nor R6 applies), `dq_oe`=0 and `dq_out`=0. This covers `we_n`=0.
- R10: Synchronous active-high `rst` clears every SRAM word to zero.
- R11: An SRAM access above the 512K-word window neither writes the array nor drives the bus, even if its low address bits match a stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for SRAM writes |
| rst | input | 1 | Synchronous active-high reset |
| bank_f_n | input | 1 | Flash bank enable, active-low |
| bank_s_n | input | 1 | SRAM enable, active-low half |
| bank_s_hi | input | 1 | SRAM enable, active-high half |
| oe_n | input | 1 | Shared output enable, active-low |
| we_n | input | 1 | Shared write enable, active-low |
| ub_n | input | 1 | Upper byte lane enable, active-low |
| lb_n | input | 1 | Lower byte lane enable, active-low |
| addr | input | 20 | Shared word address |
| wdata | input | 16 | Write data from host |
| flash_rdata | input | 16 | Read data returned by the flash array |
| flash_sel | output | 1 | Flash bank selected |
| flash_oe | output | 1 | Flash output enable |
| flash_we | output | 1 | Flash write strobe |
| sram_sel | output | 1 | SRAM bank selected |
| sram_lane_en | output | 2 | SRAM byte lanes active {upper, lower} |
| standby | output | 1 | No bank selected |
| conflict | output | 1 | Forbidden enable combination present |
| dq_out | output | 16 | Read data placed on the shared bus |
| dq_oe | output | 2 | Per-lane bus drive enable {upper, lower} |

## Verification
All 32 combinations of the three enables and the two strobes are swept. Each one is checked against select, standby, conflict, strobe and drive values worked out arithmetically. This separates the two standby conditions, the SRAM's mixed-polarity qualification and the write-inhibit by `oe_n`. A full pass writes all 64 SRAM words, cycling through the four lane masks, and then reads each word back. This tells per-lane write masking apart from whole-word writes. Single-lane reads confirm that only the requested lanes are driven. Writes attempted under the conflict combination and above the address window target a word that already holds known data, so any leak into the array shows up. A mid-run reset confirms that the array is cleared.

// File: rtl/bsel_pkg.sv
package bsel_pkg;

    localparam int LANE_W  = 8;
    localparam int DATA_W  = 16;
    localparam int N_LANES = DATA_W / LANE_W;

    typedef struct packed {
        logic flash_act;
        logic sram_req;
        logic standby;
        logic conflict;
    } bank_state_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_FLASH = 2'd1,
        SRC_SRAM  = 2'd2
    } rd_src_t;

    function automatic bank_state_t classify(input logic f_n, input logic s_n, input logic s_hi);
        bank_state_t st;
        logic sram_on;
        sram_on      = !s_n && s_hi;
        st.conflict  = !f_n && sram_on;
        st.flash_act = !f_n && !st.conflict;
        st.sram_req  = sram_on && !st.conflict;
        st.standby   = f_n && !sram_on;
        return st;
    endfunction

endpackage

// File: rtl/bank_decode.sv
module bank_decode
    import bsel_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int WIN_AW = 19
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bank_f_n,
    input  logic                 bank_s_n,
    input  logic                 bank_s_hi,
    input  logic                 oe_n,
    input  logic                 we_n,
    input  logic                 ub_n,
    input  logic                 lb_n,
    input  logic [ADDR_W-1:0]    addr,
    output bank_state_t          state,
    output logic                 flash_sel,
    output logic                 flash_oe,
    output logic                 flash_we,
    output logic                 sram_sel,
    output logic                 sram_wr,
    output logic [N_LANES-1:0]   lane_en,
    output rd_src_t              rd_src
);

    logic in_window;
    logic rd_phase;

    generate
        if (ADDR_W > WIN_AW) begin : g_win
            assign in_window = (addr[ADDR_W-1:WIN_AW] == '0);
        end else begin : g_nowin
            assign in_window = 1'b1;
        end
    endgenerate

    always_comb begin
        state     = classify(bank_f_n, bank_s_n, bank_s_hi);
        rd_phase  = !oe_n && we_n;
        flash_sel = state.flash_act;
        flash_oe  = state.flash_act && !oe_n;
        flash_we  = state.flash_act && !we_n && oe_n;
        sram_sel  = state.sram_req && in_window;
        lane_en   = sram_sel ? {!ub_n, !lb_n} : '0;
        sram_wr   = sram_sel && !we_n;
        if (flash_sel && rd_phase)
            rd_src = SRC_FLASH;
        else if (sram_sel && rd_phase)
            rd_src = SRC_SRAM;
        else
            rd_src = SRC_NONE;
    end

    // R2: SRAM select needs both halves of its enable
    a_r2_sram_qualified: assert property (@(posedge clk) disable iff (rst)
        sram_sel |-> (!bank_s_n && bank_s_hi && bank_f_n));
    // R8: flash write strobe never with low output enable
    a_r8_we_inhibit: assert property (@(posedge clk) disable iff (rst)
        flash_we |-> (oe_n && !bank_f_n));
    // R4: at most one bank active
    a_r4_one_bank: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flash_sel, sram_sel, state.conflict}));

endmodule

// File: rtl/sram_lanes.sv
module sram_lanes
    import bsel_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [N_LANES-1:0] lane_en,
    input  logic [AW-1:0]      idx,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    generate
        for (genvar ln = 0; ln < N_LANES; ln++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int w = 0; w < DEPTH; w++)
                        mem[w][ln*LANE_W +: LANE_W] <= '0;
                end else if (wr_en && lane_en[ln]) begin
                    mem[idx][ln*LANE_W +: LANE_W] <= wdata[ln*LANE_W +: LANE_W];
                end
            end
        end
    endgenerate

    assign rdata = mem[idx];

    // R7: an enabled lower lane holds the written byte after the edge
    a_r7_low_lane_written: assert property (@(posedge clk) disable iff (rst)
        (wr_en && lane_en[0]) |=> (mem[$past(idx)][LANE_W-1:0] == $past(wdata[LANE_W-1:0])));
    // R7: a disabled upper lane keeps its byte
    a_r7_high_lane_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !lane_en[1]) |=>
            (mem[$past(idx)][DATA_W-1:LANE_W] == $past(mem[idx][DATA_W-1:LANE_W])));

endmodule

// File: rtl/bus_drive.sv
module bus_drive
    import bsel_pkg::*;
(
    input  rd_src_t             rd_src,
    input  logic [N_LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0]   flash_rdata,
    input  logic [DATA_W-1:0]   sram_rdata,
    output logic [DATA_W-1:0]   dq_out,
    output logic [N_LANES-1:0]  dq_oe
);

    generate
        for (genvar ln = 0; ln < N_LANES; ln++) begin : g_lane
            always_comb begin
                unique case (rd_src)
                    SRC_FLASH: begin
                        dq_oe[ln] = 1'b1;
                        dq_out[ln*LANE_W +: LANE_W] = flash_rdata[ln*LANE_W +: LANE_W];
                    end
                    SRC_SRAM: begin
                        dq_oe[ln] = lane_en[ln];
                        dq_out[ln*LANE_W +: LANE_W] =
                            lane_en[ln] ? sram_rdata[ln*LANE_W +: LANE_W] : '0;
                    end
                    default: begin
                        dq_oe[ln] = 1'b0;
                        dq_out[ln*LANE_W +: LANE_W] = '0;
                    end
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/shared_bus_bank_sel.sv
module shared_bus_bank_sel
    import bsel_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int WIN_AW  = 19,
    parameter int SRAM_AW = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bank_f_n,
    input  logic                bank_s_n,
    input  logic                bank_s_hi,
    input  logic                oe_n,
    input  logic                we_n,
    input  logic                ub_n,
    input  logic                lb_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [15:0]         wdata,
    input  logic [15:0]         flash_rdata,
    output logic                flash_sel,
    output logic                flash_oe,
    output logic                flash_we,
    output logic                sram_sel,
    output logic [1:0]          sram_lane_en,
    output logic                standby,
    output logic                conflict,
    output logic [15:0]         dq_out,
    output logic [1:0]          dq_oe
);

    bank_state_t        st;
    rd_src_t            rd_src;
    logic               sram_wr;
    logic [N_LANES-1:0] lane_en;
    logic [DATA_W-1:0]  sram_rdata;

    bank_decode #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW)) u_dec (
        .clk(clk), .rst(rst),
        .bank_f_n(bank_f_n), .bank_s_n(bank_s_n), .bank_s_hi(bank_s_hi),
        .oe_n(oe_n), .we_n(we_n), .ub_n(ub_n), .lb_n(lb_n), .addr(addr),
        .state(st), .flash_sel(flash_sel), .flash_oe(flash_oe), .flash_we(flash_we),
        .sram_sel(sram_sel), .sram_wr(sram_wr), .lane_en(lane_en), .rd_src(rd_src)
    );

    sram_lanes #(.AW(SRAM_AW)) u_sram (
        .clk(clk), .rst(rst), .wr_en(sram_wr), .lane_en(lane_en),
        .idx(addr[SRAM_AW-1:0]), .wdata(wdata), .rdata(sram_rdata)
    );

    bus_drive u_drv (
        .rd_src(rd_src), .lane_en(lane_en), .flash_rdata(flash_rdata),
        .sram_rdata(sram_rdata), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    assign sram_lane_en = lane_en;
    assign standby      = st.standby;
    assign conflict     = st.conflict;

    // R4: forbidden combination releases the bus
    a_r4_no_drive: assert property (@(posedge clk) disable iff (rst)
        conflict |-> (dq_oe == '0 && !flash_we));
    // R3: standby never drives the bus
    a_r3_standby_quiet: assert property (@(posedge clk) disable iff (rst)
        standby |-> (dq_oe == '0 && !flash_sel && !sram_sel));
    // R9: no drive while output enable is high or a write is in progress
    a_r9_no_read_no_drive: assert property (@(posedge clk) disable iff (rst)
        (oe_n || !we_n) |-> (dq_oe == '0));
    // R5: flash read drives both lanes
    a_r5_flash_full_word: assert property (@(posedge clk) disable iff (rst)
        (flash_oe && we_n) |-> (dq_oe == 2'b11 && dq_out == flash_rdata));

endmodule

// File: tb/sim_shared_bus_bank_sel.sv
module sim_shared_bus_bank_sel;

    localparam int PERIOD = 10;
    localparam int NW     = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        bank_f_n, bank_s_n, bank_s_hi, oe_n, we_n, ub_n, lb_n;
    logic [19:0] addr;
    logic [15:0] wdata, flash_rdata;
    logic        flash_sel, flash_oe, flash_we, sram_sel, standby, conflict;
    logic [1:0]  sram_lane_en, dq_oe;
    logic [15:0] dq_out;

    int checks   = 0;
    int failures = 0;
    logic [15:0] model [NW];

    always #(PERIOD/2) clk = ~clk;

    shared_bus_bank_sel u0 (
        .clk(clk), .rst(rst), .bank_f_n(bank_f_n), .bank_s_n(bank_s_n),
        .bank_s_hi(bank_s_hi), .oe_n(oe_n), .we_n(we_n), .ub_n(ub_n), .lb_n(lb_n),
        .addr(addr), .wdata(wdata), .flash_rdata(flash_rdata),
        .flash_sel(flash_sel), .flash_oe(flash_oe), .flash_we(flash_we),
        .sram_sel(sram_sel), .sram_lane_en(sram_lane_en), .standby(standby),
        .conflict(conflict), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        bank_f_n = 1; bank_s_n = 1; bank_s_hi = 0; oe_n = 1; we_n = 1;
        ub_n = 0; lb_n = 0; wdata = '0;
    endtask

    task automatic sram_read(input logic [19:0] a, input logic u, input logic l);
        @(negedge clk);
        idle();
        bank_s_n = 0; bank_s_hi = 1; oe_n = 0; addr = a; ub_n = u; lb_n = l;
        #1;
    endtask

    task automatic sram_write(input logic [19:0] a, input logic [15:0] d,
                              input logic u, input logic l);
        @(negedge clk);
        idle();
        bank_s_n = 0; bank_s_hi = 1; we_n = 0; addr = a; wdata = d; ub_n = u; lb_n = l;
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) model[i] = '0;
        rst = 1; idle(); addr = '0; flash_rdata = 16'hA5C3;
        repeat (2) @(negedge clk);
        #1;
        check("R3 reset standby", {31'd0, standby}, 1);
        check("R9 reset dq_oe", {30'd0, dq_oe}, 0);
        @(negedge clk); rst = 0;

        // R10: array starts cleared
        for (int a = 0; a < NW; a++) begin
            sram_read(20'(a), 0, 0);
            check("R10 cleared after reset", {16'd0, dq_out}, 0);
        end

        // Sweep of enables and strobes, no writes reach an edge
        for (int c = 0; c < 32; c++) begin
            logic fe, sl, sh, oe, we, conf, fs, ss, sb, rd;
            logic [1:0]  e_oe;
            logic [15:0] e_dq;
            fe = c[4]; sl = c[3]; sh = c[2]; oe = c[1]; we = c[0];
            conf = !fe && !sl && sh;
            fs   = !fe && !conf;
            ss   = !sl && sh && !conf;
            sb   = fe && !(!sl && sh);
            rd   = !oe && we;
            e_oe = ((fs || ss) && rd) ? 2'b11 : 2'b00;
            e_dq = (fs && rd) ? 16'hA5C3 : 16'h0000;
            @(negedge clk);
            bank_f_n = fe; bank_s_n = sl; bank_s_hi = sh; oe_n = oe; we_n = we;
            ub_n = 0; lb_n = 0; addr = 20'd5; wdata = 16'hFFFF;
            #2;
            check("R4 conflict", {31'd0, conflict}, {31'd0, conf});
            check("R1 flash_sel", {31'd0, flash_sel}, {31'd0, fs});
            check("R1 flash_oe", {31'd0, flash_oe}, {31'd0, fs && !oe});
            check("R8 flash_we", {31'd0, flash_we}, {31'd0, fs && !we && oe});
            check("R2 sram_sel", {31'd0, sram_sel}, {31'd0, ss});
            check("R7 lane_en", {30'd0, sram_lane_en}, ss ? 2'b11 : 2'b00);
            check("R3 standby", {31'd0, standby}, {31'd0, sb});
            check("R5 R9 dq_oe", {30'd0, dq_oe}, {30'd0, e_oe});
            check("R5 R9 dq_out", {16'd0, dq_out}, {16'd0, e_dq});
            #1;
            idle();
        end

        // R5: flash read with other data words
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            idle();
            bank_f_n = 0; oe_n = 0; flash_rdata = 16'h1234 * 16'(k + 1);
            #1;
            check("R5 flash data", {16'd0, dq_out}, {16'd0, 16'h1234 * 16'(k + 1)});
            check("R5 flash lanes", {30'd0, dq_oe}, 2'b11);
        end

        // R7: lane-masked writes across the whole array
        for (int a = 0; a < NW; a++) begin
            logic [15:0] d;
            logic [1:0]  m;
            d = 16'(a) * 16'h0103 ^ 16'h5A00;
            m = 2'(a % 4);
            sram_write(20'(a), d, !m[1], !m[0]);
            if (m[1]) model[a][15:8] = d[15:8];
            if (m[0]) model[a][7:0]  = d[7:0];
        end
        for (int a = 0; a < NW; a++) begin
            sram_read(20'(a), 0, 0);
            check("R7 readback", {16'd0, dq_out}, {16'd0, model[a]});
            check("R6 both lanes", {30'd0, dq_oe}, 2'b11);
        end

        // R6: single-lane reads
        for (int a = 0; a < 4; a++) begin
            sram_read(20'(a + 8), 0, 1);
            check("R6 upper only data", {16'd0, dq_out}, {16'd0, model[a+8][15:8], 8'h00});
            check("R6 upper only oe", {30'd0, dq_oe}, 2'b10);
            sram_read(20'(a + 8), 1, 0);
            check("R6 lower only data", {16'd0, dq_out}, {16'd0, 8'h00, model[a+8][7:0]});
            check("R6 lower only oe", {30'd0, dq_oe}, 2'b01);
            sram_read(20'(a + 8), 1, 1);
            check("R6 no lanes", {30'd0, dq_oe}, 2'b00);
        end

        // R4: write attempt under conflict
        @(negedge clk);
        idle();
        bank_f_n = 0; bank_s_n = 0; bank_s_hi = 1; we_n = 0; addr = 20'd7; wdata = 16'hFFFF;
        #1;
        check("R4 conflict flag", {31'd0, conflict}, 1);
        check("R4 no flash_we", {31'd0, flash_we}, 0);
        @(negedge clk);
        idle();
        bank_f_n = 0; bank_s_n = 0; bank_s_hi = 1; oe_n = 0; addr = 20'd7;
        #1;
        check("R4 no drive", {30'd0, dq_oe}, 0);
        sram_read(20'd7, 0, 0);
        check("R4 array unchanged", {16'd0, dq_out}, {16'd0, model[7]});

        // R11: access above the window
        @(negedge clk);
        idle();
        bank_s_n = 0; bank_s_hi = 1; we_n = 0; addr = 20'h80007; wdata = 16'hFFFF;
        #1;
        check("R11 outside sel", {31'd0, sram_sel}, 0);
        check("R11 outside lanes", {30'd0, sram_lane_en}, 0);
        @(negedge clk);
        idle();
        sram_read(20'h80007, 0, 0);
        check("R11 outside no drive", {30'd0, dq_oe}, 0);
        sram_read(20'd7, 0, 0);
        check("R11 alias unchanged", {16'd0, dq_out}, {16'd0, model[7]});

        // R10: reset in mid-run clears contents
        @(negedge clk);
        idle();
        rst = 1;
        @(negedge clk);
        rst = 0;
        for (int a = 0; a < 8; a++) begin
            sram_read(20'(a), 0, 0);
            check("R10 cleared mid-run", {16'd0, dq_out}, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule